// File: doc/BRIEF.md
# Multi-Step ADC Conversion Sequencer

This block orders the conversions of one shared analog-to-digital converter across sixteen programmable steps. Each step names one of eight analog input lines, whether its result is the mean of sixteen samples or a single sample, which of two result queues gets its result, whether it repeats on every pass or runs once, and an open delay. The delay is a number of idle cycles that pass before the first conversion request of the step.

A 17-bit enable register chooses which steps run. Step n is enabled by register bit n+1. Bit 0 is reserved and always reads zero. While the global enable is high, the sequencer picks the lowest enabled step and walks upward. For each step it waits out the open delay, asks the converter for samples, and accumulates them. It then presents one result word that carries the step number. A one-shot step clears its own enable bit when its result is written. A continuous step keeps its bit and runs again on the next pass. When no enabled step is left, the block returns to idle. Dropping the global enable abandons the step in progress.

Top module: `adc_step_sequencer`

## Requirements
- R1: A conversion request carries the input line configured for the step being converted, and that step's result data is derived from the samples returned for that line.
- R2: Within a pass, steps are serviced in ascending step number. After the highest enabled step, the next pass restarts at the lowest step still enabled.
- R3: Step n is enabled by enable-register bit n+1. Bit 0 always reads 0, and a write that sets only bit 0 starts no conversion.
- R4: A step with averaging on issues exactly 16 conversion requests. Its result is the 16-sample sum shifted right by 4.
- R5: A step with averaging off issues exactly one conversion request, and its result equals that sample.
- R6: When a one-shot step's result is written, that step's enable bit is cleared. A continuous step's bit stays set, and the step is serviced again on the following pass.
- R7: When no enabled step remains after a result, the sequencer goes idle and no further results appear.
- R8: The first conversion request of a step comes exactly as many cycles later as the step's open-delay value, compared with a delay of zero.
- R9: A result word holds the 12-bit data in bits 11:0 and the step number in bits 19:16. All other bits are zero. The queue-select output equals the step's configured queue bit.
- R10: Busy rises once a pass starts and stays high until the cycle in which the last result of the run is presented.
- R11: Clearing the global enable makes busy low, and suppresses conversion requests and results, from the next cycle on. The aborted step produces no result and keeps its enable bit.
- R12: While the global enable is low, no conversion request is issued, even if steps are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_en | input | 1 | Global enable; low aborts and holds idle |
| cfg_we | input | 1 | Write strobe for one step's configuration |
| cfg_idx | input | 4 | Step number written |
| cfg_line | input | 3 | Analog input line for the step |
| cfg_avg | input | 1 | 1 = average 16 samples, 0 = single sample |
| cfg_fifo | input | 1 | Result queue select for the step |
| cfg_cont | input | 1 | 1 = continuous, 0 = one-shot |
| cfg_dly | input | 8 | Open delay in cycles |
| mask_we | input | 1 | Write strobe for the enable register |
| mask_wdata | input | 17 | New enable register value (bit n+1 = step n) |
| step_en | output | 17 | Current enable register |
| busy | output | 1 | Sequencer is working through a run |
| conv_start | output | 1 | One-cycle conversion request |
| conv_line | output | 3 | Input line for the requested conversion |
| conv_done | input | 1 | Converter sample valid strobe |
| conv_sample | input | 12 | Converter sample |
| res_valid | output | 1 | Result word valid for one cycle |
| res_fifo | output | 1 | Queue select for the result |
| res_word | output | 32 | Result: data 11:0, step number 19:16 |

## Verification
A wrong step cursor shows up at once in the step tag of the next result word, and in the line sent with the next conversion request, well within one step's time. A corrupt sample counter or accumulator is visible in the number of conversion requests before the result and in the averaged data of that same result. A wrong enable-register update shows on step_en in the cycle after the result, and again a pass later, when a continuous step is missing or a one-shot step repeats. A failed abort is visible one cycle after the global enable falls, as busy or a request that is still active.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int LINE_W = 3;
    localparam int DLY_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_CONV  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              avg;
        logic              fifo;
        logic              cont;
        logic [DLY_W-1:0]  dly;
    } step_cfg_t;
endpackage

// File: rtl/adc_step_bank.sv
module adc_step_bank
    import adc_seq_pkg::*;
#(
    parameter int NUM_STEPS = 16,
    localparam int IDX_W = $clog2(NUM_STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  step_cfg_t        wr_cfg,
    input  logic [IDX_W-1:0] rd_idx,
    output step_cfg_t        rd_cfg
);
    step_cfg_t bank_q [NUM_STEPS];
    step_cfg_t bank_d [NUM_STEPS];

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
        always_comb begin
            bank_d[g] = bank_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                bank_d[g] = wr_cfg;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else begin
                bank_q[g] <= bank_d[g];
            end
        end
    end

    assign rd_cfg = bank_q[rd_idx];
endmodule

// File: rtl/adc_step_pick.sv
module adc_step_pick #(
    parameter int NUM_STEPS = 16,
    localparam int IDX_W = $clog2(NUM_STEPS)
) (
    input  logic [NUM_STEPS-1:0] mask,
    input  logic [IDX_W:0]       floor_idx,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);
    // lowest set bit at or above floor_idx
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_STEPS - 1; i >= 0; i--) begin
            if (mask[i] && ((IDX_W+1)'(i) >= floor_idx)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/adc_step_sequencer.sv
module adc_step_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NUM_STEPS = 16,
    parameter int SAMPLE_W  = 12,
    parameter int AVG_LOG2  = 4,
    parameter int RES_W     = 32,
    parameter int ID_POS    = 16,
    localparam int IDX_W    = $clog2(NUM_STEPS),
    localparam int ACC_W    = SAMPLE_W + AVG_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seq_en,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [LINE_W-1:0]   cfg_line,
    input  logic                cfg_avg,
    input  logic                cfg_fifo,
    input  logic                cfg_cont,
    input  logic [DLY_W-1:0]    cfg_dly,
    input  logic                mask_we,
    input  logic [NUM_STEPS:0]  mask_wdata,
    output logic [NUM_STEPS:0]  step_en,
    output logic                busy,
    output logic                conv_start,
    output logic [LINE_W-1:0]   conv_line,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_sample,
    output logic                res_valid,
    output logic                res_fifo,
    output logic [RES_W-1:0]    res_word
);
    typedef struct packed {
        seq_state_e          st;
        logic [IDX_W-1:0]    cur;
        logic [DLY_W-1:0]    wait_cnt;
        logic [AVG_LOG2-1:0] nsamp;
        logic [ACC_W-1:0]    acc;
        logic [NUM_STEPS:0]  en;
        logic                start;
        logic                rvalid;
        logic                rfifo;
        logic [RES_W-1:0]    rword;
        logic                busy;
    } seq_regs_t;

    seq_regs_t q, d;

    step_cfg_t wr_cfg, cur_cfg;
    logic [NUM_STEPS:0]   en_host;
    logic [NUM_STEPS-1:0] run_mask, keep_mask;
    logic [IDX_W:0]       floor_next;
    logic                 first_found, next_found, wrap_found;
    logic [IDX_W-1:0]     first_idx, next_idx, wrap_idx;
    logic [ACC_W-1:0]     sum;
    logic [SAMPLE_W-1:0]  result_val;

    always_comb begin
        wr_cfg.line = cfg_line;
        wr_cfg.avg  = cfg_avg;
        wr_cfg.fifo = cfg_fifo;
        wr_cfg.cont = cfg_cont;
        wr_cfg.dly  = cfg_dly;
    end

    adc_step_bank #(.NUM_STEPS(NUM_STEPS)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_cfg (wr_cfg),
        .rd_idx (q.cur),
        .rd_cfg (cur_cfg)
    );

    // host write first, reserved bit forced low
    always_comb begin
        en_host    = mask_we ? mask_wdata : q.en;
        en_host[0] = 1'b0;
        run_mask   = en_host[NUM_STEPS:1];
        keep_mask  = run_mask;
        if (!cur_cfg.cont) begin
            keep_mask[q.cur] = 1'b0;
        end
        floor_next = (IDX_W+1)'(q.cur) + 1'b1;
        sum        = q.acc + ACC_W'(conv_sample);
        result_val = cur_cfg.avg ? sum[ACC_W-1 -: SAMPLE_W] : sum[SAMPLE_W-1:0];
    end

    adc_step_pick #(.NUM_STEPS(NUM_STEPS)) i_pick_first (
        .mask (run_mask), .floor_idx ('0),
        .found(first_found), .idx(first_idx)
    );
    adc_step_pick #(.NUM_STEPS(NUM_STEPS)) i_pick_next (
        .mask (keep_mask), .floor_idx (floor_next),
        .found(next_found), .idx(next_idx)
    );
    adc_step_pick #(.NUM_STEPS(NUM_STEPS)) i_pick_wrap (
        .mask (keep_mask), .floor_idx ('0),
        .found(wrap_found), .idx(wrap_idx)
    );

    always_comb begin
        d        = q;
        d.en     = en_host;
        d.start  = 1'b0;
        d.rvalid = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (seq_en && first_found) begin
                    d.cur      = first_idx;
                    d.wait_cnt = '0;
                    d.st       = ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (q.wait_cnt == cur_cfg.dly) begin
                    d.start = 1'b1;
                    d.acc   = '0;
                    d.nsamp = '0;
                    d.st    = ST_CONV;
                end else begin
                    d.wait_cnt = q.wait_cnt + 1'b1;
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    if (cur_cfg.avg && (q.nsamp != '1)) begin
                        d.acc   = sum;
                        d.nsamp = q.nsamp + 1'b1;
                        d.start = 1'b1;
                    end else begin
                        d.rvalid                   = 1'b1;
                        d.rfifo                    = cur_cfg.fifo;
                        d.rword                    = '0;
                        d.rword[SAMPLE_W-1:0]      = result_val;
                        d.rword[ID_POS +: IDX_W]   = q.cur;
                        d.en                       = {keep_mask, 1'b0};
                        d.wait_cnt                 = '0;
                        if (next_found) begin
                            d.cur = next_idx;
                            d.st  = ST_DELAY;
                        end else if (wrap_found) begin
                            d.cur = wrap_idx;
                            d.st  = ST_DELAY;
                        end else begin
                            d.st  = ST_IDLE;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (!seq_en) begin
            d.st     = ST_IDLE;
            d.start  = 1'b0;
            d.rvalid = 1'b0;
            d.en     = en_host;
        end
        d.busy = (d.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign step_en    = q.en;
    assign busy       = q.busy;
    assign conv_start = q.start;
    assign conv_line  = cur_cfg.line;
    assign res_valid  = q.rvalid;
    assign res_fifo   = q.rfifo;
    assign res_word   = q.rword;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int SAMPLE_W = 12,
    parameter int RES_W    = 32,
    parameter int ID_POS   = 16,
    parameter int IDX_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seq_en,
    input logic             busy,
    input logic             conv_start,
    input logic             res_valid,
    input logic [RES_W-1:0] res_word,
    input logic             en_bit0
);
    localparam logic [RES_W-1:0] DATA_MASK  = RES_W'((64'd1 << SAMPLE_W) - 64'd1);
    localparam logic [RES_W-1:0] TAG_MASK   = RES_W'(((64'd1 << IDX_W) - 64'd1) << ID_POS);
    localparam logic [RES_W-1:0] FIELD_MASK = DATA_MASK | TAG_MASK;

    a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_en |=> !busy);

    a_r11_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_en |=> (!conv_start && !res_valid));

    a_r10_busy_until_result: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (res_valid || !$past(seq_en)));

    a_r10_request_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    a_r9_word_format: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_word & ~FIELD_MASK) == '0));

    a_r3_reserved_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !en_bit0);
endmodule

bind adc_step_sequencer adc_seq_checker #(
    .SAMPLE_W (SAMPLE_W),
    .RES_W    (RES_W),
    .ID_POS   (ID_POS),
    .IDX_W    (IDX_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_en     (seq_en),
    .busy       (busy),
    .conv_start (conv_start),
    .res_valid  (res_valid),
    .res_word   (res_word),
    .en_bit0    (step_en[0])
);

// File: tb/test_adc_step_sequencer.sv
module test_adc_step_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seq_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [2:0]  cfg_line = '0;
    logic        cfg_avg = 1'b0;
    logic        cfg_fifo = 1'b0;
    logic        cfg_cont = 1'b0;
    logic [7:0]  cfg_dly = '0;
    logic        mask_we = 1'b0;
    logic [16:0] mask_wdata = '0;
    logic [16:0] step_en;
    logic        busy, conv_start, res_valid, res_fifo;
    logic [2:0]  conv_line;
    logic        conv_done = 1'b0;
    logic [11:0] conv_sample = '0;
    logic [31:0] res_word;

    always #10 clk = ~clk;

    adc_step_sequencer i_adc_step_sequencer (
        .clk(clk), .rst_n(rst_n), .seq_en(seq_en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_line(cfg_line),
        .cfg_avg(cfg_avg), .cfg_fifo(cfg_fifo), .cfg_cont(cfg_cont),
        .cfg_dly(cfg_dly), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .step_en(step_en), .busy(busy), .conv_start(conv_start),
        .conv_line(conv_line), .conv_done(conv_done),
        .conv_sample(conv_sample), .res_valid(res_valid),
        .res_fifo(res_fifo), .res_word(res_word)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int res_n = 0;
    int st_n = 0;
    logic [31:0] res_log [256];
    logic        fifo_log [256];
    int          st_cyc [512];
    int          stub_mode = 0;
    int          stub_cnt = 0;
    int          stub_k = 0;
    logic [2:0]  stub_line = '0;

    // output monitor, just after each rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        if (res_valid) begin
            res_log[res_n % 256]  = res_word;
            fifo_log[res_n % 256] = res_fifo;
            res_n++;
        end
        if (conv_start) begin
            st_cyc[st_n % 512] = cyc;
            st_n++;
        end
    end

    // converter stub: answers each request three falling edges later
    // mode 0: line*256+7, mode 1: line*256 + 3*k for k-th sample of a run
    always @(negedge clk) begin
        if (!busy) stub_k = 0;
        conv_done = 1'b0;
        if (stub_cnt > 0) begin
            stub_cnt--;
            if (stub_cnt == 0) begin
                conv_done = 1'b1;
                if (stub_mode == 0)
                    conv_sample = 12'(int'(stub_line) * 256 + 7);
                else
                    conv_sample = 12'(int'(stub_line) * 256 + stub_k * 3);
                stub_k = (stub_k + 1) % 16;
            end
        end
        if (conv_start) begin
            stub_line = conv_line;
            stub_cnt  = 3;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_step(input int idx, input int line, input bit avg,
                            input bit fifo, input bit cont, input int dly);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_line = 3'(line);
        cfg_avg = avg; cfg_fifo = fifo; cfg_cont = cont; cfg_dly = 8'(dly);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_mask(input logic [16:0] v);
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = v;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic set_en(input bit v);
        @(negedge clk);
        seq_en = v;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        @(negedge clk);
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, req, int'(busy), 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R10", int'(busy), 0);
        chk(step_en == 17'h0, "R3", int'(step_en), 0);
        chk(conv_start == 1'b0 && res_valid == 1'b0, "R12", int'(conv_start), 0);
    endtask

    task automatic t_reserved_bit();
        int sb;
        write_mask(17'h00001);
        chk(step_en == 17'h0, "R3", int'(step_en), 0);
        sb = st_n;
        set_en(1'b1);
        repeat (20) @(negedge clk);
        chk(st_n == sb, "R3", st_n - sb, 0);
        chk(busy == 1'b0, "R3", int'(busy), 0);
        set_en(1'b0);
    endtask

    task automatic t_oneshot_pass();
        int rb, sb;
        int tags [3]  = '{2, 9, 15};
        int lines [3] = '{5, 3, 7};
        bit fifos [3] = '{1'b1, 1'b0, 1'b1};
        cfg_step(2, 5, 1'b0, 1'b1, 1'b0, 0);
        cfg_step(9, 3, 1'b0, 1'b0, 1'b0, 1);
        cfg_step(15, 7, 1'b0, 1'b1, 1'b0, 0);
        write_mask(17'h10409);
        chk(step_en == 17'h10408, "R3", int'(step_en), 'h10408);
        rb = res_n; sb = st_n;
        set_en(1'b1);
        @(negedge clk); @(negedge clk);
        chk(busy == 1'b1, "R10", int'(busy), 1);
        wait_idle("R7");
        chk(res_n - rb == 3, "R7", res_n - rb, 3);
        chk(st_n - sb == 3, "R5", st_n - sb, 3);
        for (int i = 0; i < 3; i++) begin
            logic [31:0] w;
            w = res_log[(rb + i) % 256];
            chk(int'(w[19:16]) == tags[i], "R2", int'(w[19:16]), tags[i]);
            chk(int'(w[11:0]) == lines[i] * 256 + 7, "R1", int'(w[11:0]), lines[i] * 256 + 7);
            chk(w[31:20] == 12'h0 && w[15:12] == 4'h0, "R9", int'(w[31:20]), 0);
            chk(fifo_log[(rb + i) % 256] == fifos[i], "R9",
                int'(fifo_log[(rb + i) % 256]), int'(fifos[i]));
        end
        chk(step_en == 17'h0, "R6", int'(step_en), 0);
        repeat (10) @(negedge clk);
        chk(res_n - rb == 3, "R7", res_n - rb, 3);
        set_en(1'b0);
    endtask

    task automatic t_average();
        int rb, sb;
        stub_mode = 1;
        cfg_step(4, 2, 1'b1, 1'b0, 1'b0, 2);
        write_mask(17'h00020);
        rb = res_n; sb = st_n;
        set_en(1'b1);
        wait_idle("R4");
        chk(st_n - sb == 16, "R4", st_n - sb, 16);
        chk(res_n - rb == 1, "R4", res_n - rb, 1);
        chk(int'(res_log[rb % 256][11:0]) == 534, "R4", int'(res_log[rb % 256][11:0]), 534);
        chk(int'(res_log[rb % 256][19:16]) == 4, "R9", int'(res_log[rb % 256][19:16]), 4);
        set_en(1'b0);
        stub_mode = 0;
    endtask

    task automatic t_continuous();
        int rb, n;
        int exp_tags [4] = '{1, 6, 1, 1};
        cfg_step(1, 1, 1'b0, 1'b0, 1'b1, 0);
        cfg_step(6, 6, 1'b0, 1'b1, 1'b0, 0);
        write_mask(17'h00084);
        rb = res_n;
        set_en(1'b1);
        n = 0;
        while ((res_n - rb) < 4 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        seq_en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && conv_start == 1'b0, "R11", int'(busy), 0);
        repeat (10) @(negedge clk);
        chk(res_n - rb == 4, "R11", res_n - rb, 4);
        for (int i = 0; i < 4; i++) begin
            chk(int'(res_log[(rb + i) % 256][19:16]) == exp_tags[i], "R6",
                int'(res_log[(rb + i) % 256][19:16]), exp_tags[i]);
        end
        chk(step_en == 17'h00004, "R6", int'(step_en), 4);
        write_mask(17'h0);
    endtask

    task automatic t_delay();
        int t0, sb, d0, d9;
        cfg_step(0, 0, 1'b0, 1'b0, 1'b0, 0);
        write_mask(17'h00002);
        sb = st_n;
        @(negedge clk);
        seq_en = 1'b1; t0 = cyc;
        wait_idle("R8");
        d0 = st_cyc[sb % 512] - t0;
        set_en(1'b0);
        cfg_step(0, 0, 1'b0, 1'b0, 1'b0, 9);
        write_mask(17'h00002);
        sb = st_n;
        @(negedge clk);
        seq_en = 1'b1; t0 = cyc;
        wait_idle("R8");
        d9 = st_cyc[sb % 512] - t0;
        chk(d9 - d0 == 9, "R8", d9 - d0, 9);
        set_en(1'b0);
    endtask

    task automatic t_abort_and_hold();
        int rb, sb, n;
        stub_mode = 1;
        cfg_step(3, 4, 1'b1, 1'b1, 1'b0, 0);
        write_mask(17'h00010);
        rb = res_n; sb = st_n;
        set_en(1'b1);
        n = 0;
        while ((st_n - sb) < 3 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        seq_en = 1'b0;
        sb = st_n;
        @(negedge clk);
        chk(busy == 1'b0, "R11", int'(busy), 0);
        chk(conv_start == 1'b0, "R11", int'(conv_start), 0);
        repeat (20) @(negedge clk);
        chk(res_n == rb, "R11", res_n - rb, 0);
        chk(step_en == 17'h00010, "R11", int'(step_en), 'h10);
        chk(st_n == sb, "R12", st_n - sb, 0);
        set_en(1'b1);
        wait_idle("R4");
        chk(res_n - rb == 1, "R4", res_n - rb, 1);
        chk(int'(res_log[rb % 256][11:0]) == 1046, "R4", int'(res_log[rb % 256][11:0]), 1046);
        chk(step_en == 17'h0, "R6", int'(step_en), 0);
        set_en(1'b0);
        stub_mode = 0;
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reserved_bit();
        t_oneshot_pass();
        t_average();
        t_continuous();
        t_delay();
        t_abort_and_hold();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule